// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

The controller collects up to 64 level-sensitive interrupt inputs into two 32-bit pending words and gates them with two 32-bit enable words. Software reaches the block through a small register port. It can read and write the enable words, read the pending words and drop pending bits by writing ones. It can also read a vector register that names the winning source. A single registered request line tells the processor that at least one enabled source is pending.

Source numbers do not land on matching bit positions. A fixed scatter rule assigns each source a word and a bit number. Bit numbers count from the most significant end, so bit number b is physical bit 31-b. Word index 0 is the high word and word index 1 is the low word. The rule is a bijection: every physical bit of both words belongs to exactly one source. Source 0 is reserved as the "no interrupt" code. Its input is ignored and its bit never becomes pending.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset both enable words, both pending words, `irq_o` and the vector field all read zero.
- R2: Word index 0 (high) is used by sources 16-31 and 48-63; word index 1 (low) by sources 0-15 and 32-47. Bit numbers: source 0 takes 31, sources 1-15 take n+15, source 16 takes 29, 17 takes 30, sources 18-30 take n-2, 31 takes 31, sources 32-47 take n-32, sources 48-63 take 63-n. The physical bit is 31 minus the bit number.
- R3: A high source input sets its pending bit on the next clock edge whatever the enable state, and the bit stays set after the input falls.
- R4: Writing a pending word clears each bit written as 1 and leaves bits written as 0 alone. A source that is high in the same cycle keeps its bit set.
- R5: The enable words read back what was last written; a 1 enables the source in that position.
- R6: The vector register holds, in bits [31:26], the lowest nonzero source number that is both pending and enabled, or 0 when none is. Bits [25:0] read 0. It follows the current state with no added delay.
- R7: `irq_o` equals the OR over both words of pending AND enable, as it stood one clock earlier.
- R8: Source input 0 never sets any pending bit.
- R9: Register offsets: 0 enable high, 1 enable low, 2 pending high, 3 pending low, 4 vector. Offsets 5-7 read 0. Writes to offset 4 and to 5-7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Level interrupt inputs, indexed by source number |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
The hardest case to reach is a source being raised in the same cycle that software writes a 1 to clear its bit. The bench holds the source high across the write cycle, then drops it and reads the word back to show the bit survived. Priority is checked by raising a source together with higher-numbered ones and masking, so the encoder has to pick among several active sources. The scatter rule is swept over all 64 sources, each one on its own.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NUM_SRC   = 64;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_WORDS = NUM_SRC / WORD_W;
  localparam int unsigned CODE_W    = $clog2(NUM_SRC);

  // Word index of a source: 0 = high word, 1 = low word.
  function automatic int unsigned src_word(input int unsigned n);
    if (n < 16 || (n >= 32 && n < 48)) return 1;
    return 0;
  endfunction

  // MSB-first bit number of a source within its word.
  function automatic int unsigned src_bitnum(input int unsigned n);
    if (n == 0)        return 31;
    else if (n < 16)   return n + 15;
    else if (n == 16)  return 29;
    else if (n == 17)  return 30;
    else if (n < 31)   return n - 2;
    else if (n == 31)  return 31;
    else if (n < 48)   return n - 32;
    else               return 63 - n;
  endfunction

  // Physical bit position inside the word.
  function automatic int unsigned src_pos(input int unsigned n);
    return (WORD_W - 1) - src_bitnum(n);
  endfunction
endpackage

// File: rtl/irqc_scatter.sv
module irqc_scatter
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC  = NUM_SRC,
  parameter int unsigned W_W    = WORD_W,
  parameter int unsigned N_WORD = NUM_WORDS
) (
  input  logic [N_SRC-1:0]             src_i,
  input  logic [N_WORD-1:0][W_W-1:0]   pend_i,
  input  logic [N_WORD-1:0][W_W-1:0]   mask_i,
  output logic [N_WORD-1:0][W_W-1:0]   set_o,
  output logic [N_SRC-1:0]             act_o
);
  // Source order -> word/bit order, source 0 reserved.
  always_comb begin
    set_o = '0;
    for (int n = 1; n < int'(N_SRC); n++) begin
      set_o[src_word(n)][src_pos(n)] = src_i[n];
    end
  end

  // Word/bit order -> source order for the priority encoder.
  always_comb begin
    act_o = '0;
    for (int n = 1; n < int'(N_SRC); n++) begin
      act_o[n] = pend_i[src_word(n)][src_pos(n)] & mask_i[src_word(n)][src_pos(n)];
    end
  end
endmodule

// File: rtl/irqc_pend_bank.sv
module irqc_pend_bank #(
  parameter int unsigned W_W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W_W-1:0] set_i,
  input  logic [W_W-1:0] clr_i,
  input  logic           mask_we,
  input  logic [W_W-1:0] mask_wdata,
  output logic [W_W-1:0] pend_o,
  output logic [W_W-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= '0;
      mask_o <= '0;
    end else begin
      pend_o <= (pend_o & ~clr_i) | set_i;
      if (mask_we) mask_o <= mask_wdata;
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned N_SRC = 64,
  localparam int unsigned C_W  = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] act_i,
  output logic [C_W-1:0]   code_o
);
  always_comb begin
    code_o = '0;
    for (int i = int'(N_SRC) - 1; i >= 1; i--) begin
      if (act_i[i]) code_o = C_W'(i);
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC  = NUM_SRC,
  parameter int unsigned W_W    = WORD_W,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W_W-1:0]    bus_wdata,
  output logic [W_W-1:0]    bus_rdata,
  output logic              irq_o
);
  localparam int unsigned N_WORD   = N_SRC / W_W;
  localparam int unsigned C_W      = $clog2(N_SRC);
  localparam int unsigned MASK_OFS = 0;
  localparam int unsigned PEND_OFS = MASK_OFS + N_WORD;
  localparam int unsigned VEC_OFS  = PEND_OFS + N_WORD;

  logic [N_WORD-1:0][W_W-1:0] pend_w, mask_w, set_w;
  logic [N_SRC-1:0]           act_src;
  logic [C_W-1:0]             code;
  logic [W_W-1:0]             vec_word;
  logic                       irq_q;

  irqc_scatter #(.N_SRC(N_SRC), .W_W(W_W), .N_WORD(N_WORD)) u_scatter (
    .src_i  (src_i),
    .pend_i (pend_w),
    .mask_i (mask_w),
    .set_o  (set_w),
    .act_o  (act_src)
  );

  for (genvar w = 0; w < N_WORD; w++) begin : g_bank
    logic           mask_we;
    logic [W_W-1:0] clr;
    assign mask_we = bus_we && (bus_addr == ADDR_W'(MASK_OFS + w));
    assign clr     = (bus_we && (bus_addr == ADDR_W'(PEND_OFS + w))) ? bus_wdata : '0;

    irqc_pend_bank #(.W_W(W_W)) u_bank (
      .clk        (clk),
      .rst        (rst),
      .set_i      (set_w[w]),
      .clr_i      (clr),
      .mask_we    (mask_we),
      .mask_wdata (bus_wdata),
      .pend_o     (pend_w[w]),
      .mask_o     (mask_w[w])
    );
  end

  irqc_prio #(.N_SRC(N_SRC)) u_prio (
    .act_i  (act_src),
    .code_o (code)
  );

  assign vec_word = {code, {(W_W - C_W){1'b0}}};

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < int'(N_WORD); w++) begin
      if (bus_addr == ADDR_W'(MASK_OFS + w)) bus_rdata = mask_w[w];
      if (bus_addr == ADDR_W'(PEND_OFS + w)) bus_rdata = pend_w[w];
    end
    if (bus_addr == ADDR_W'(VEC_OFS)) bus_rdata = vec_word;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(pend_w & mask_w);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned W_W    = 32,
  parameter int unsigned N_WORD = 2,
  parameter int unsigned ADDR_W = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_we,
  input logic [W_W-1:0]             bus_wdata,
  input logic [W_W-1:0]             bus_rdata,
  input logic                       irq_o,
  input logic [N_WORD-1:0][W_W-1:0] pend_w,
  input logic [N_WORD-1:0][W_W-1:0] mask_w,
  input logic [N_WORD-1:0][W_W-1:0] set_w
);
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    ((pend_w & mask_w) != '0) |=> irq_o); // R7
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
    ((pend_w & mask_w) == '0) |=> !irq_o); // R7
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
    (set_w != '0) |=> ((pend_w & $past(set_w)) == $past(set_w))); // R3
  AST_W1C_HI: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(2)) |=>
      ((pend_w[0] & $past(bus_wdata) & ~$past(set_w[0])) == '0)); // R4
  AST_MASK_WR: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(1)) |=> (mask_w[1] == $past(bus_wdata))); // R5
  AST_VEC_FIELD: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(4)) |->
      (bus_rdata[25:0] == '0 &&
       ((bus_rdata[31:26] == '0) == ((pend_w & mask_w) == '0)))); // R6
  AST_SRC0_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pend_w[1][0]); // R8
endmodule

bind irq_vector_ctrl irqc_chk #(.W_W(W_W), .N_WORD(N_WORD), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .pend_w    (pend_w),
  .mask_w    (mask_w),
  .set_w     (set_w)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_i = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  // Expected register offset (2 = high, 3 = low) and physical bit, per R2.
  function automatic int exp_ofs(input int n);
    return ((n / 16) % 2 == 0) ? 3 : 2;
  endfunction
  function automatic int exp_pos(input int n);
    if (n == 0 || n == 31) return 0;
    if (n < 16)  return 16 - n;
    if (n == 16) return 2;
    if (n == 17) return 1;
    if (n < 31)  return 33 - n;
    if (n < 48)  return 63 - n;
    return n - 32;
  endfunction

  task automatic clear_all();
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] d, hi, lo;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d); check("R1 reset reg", d, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);

    // R5 enable readback
    wr(3'd0, 32'hA5A5_0F0F); rd(3'd0, d); check("R5 mask hi", d, 32'hA5A5_0F0F);
    wr(3'd1, 32'h1234_5678); rd(3'd1, d); check("R5 mask lo", d, 32'h1234_5678);
    // R9 unused offsets and vector writes
    wr(3'd4, 32'hFFFF_FFFF); wr(3'd5, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R9 mask hi untouched", d, 32'hA5A5_0F0F);
    rd(3'd1, d); check("R9 mask lo untouched", d, 32'h1234_5678);
    rd(3'd2, hi); rd(3'd3, lo); check("R9 pending untouched", hi | lo, 32'h0);
    rd(3'd4, d); check("R9 vector untouched", d, 32'h0);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), d); check("R9 unused reads zero", d, 32'h0);
    end

    // R2/R3/R6/R7 sweep over every source, all enabled
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
    for (int n = 0; n < 64; n++) begin
      @(negedge clk); src_i = 64'd1 << n;
      @(negedge clk); src_i = '0;
      @(negedge clk);
      rd(3'd2, hi); rd(3'd3, lo);
      if (n == 0) begin
        check("R8 source 0 ignored", hi | lo, 32'h0);
        rd(3'd4, d); check("R8 vector none", d, 32'h0);
        check("R8 no irq", {31'b0, irq_o}, 32'h0);
      end else begin
        check($sformatf("R2 R3 src %0d high word", n), hi,
              exp_ofs(n) == 2 ? (32'd1 << exp_pos(n)) : 32'h0);
        check($sformatf("R2 R3 src %0d low word", n), lo,
              exp_ofs(n) == 3 ? (32'd1 << exp_pos(n)) : 32'h0);
        rd(3'd4, d); check($sformatf("R6 vector src %0d", n), d, {n[5:0], 26'b0});
        check($sformatf("R7 irq src %0d", n), {31'b0, irq_o}, 32'h1);
      end
      clear_all();
      check($sformatf("R7 irq clears src %0d", n), {31'b0, irq_o}, 32'h0);
    end

    // R3 pending while disabled; R6/R7 silent
    wr(3'd0, 32'h0); wr(3'd1, 32'h0);
    @(negedge clk); src_i = 64'd1 << 40;
    @(negedge clk); src_i = '0;
    @(negedge clk);
    rd(3'd3, d); check("R3 pend while masked", d, 32'd1 << 23);
    rd(3'd4, d); check("R6 masked gives zero vector", d, 32'h0);
    check("R7 masked no irq", {31'b0, irq_o}, 32'h0);
    wr(3'd1, 32'd1 << 23); @(negedge clk);
    rd(3'd4, d); check("R6 unmask reveals 40", d, {6'd40, 26'b0});
    check("R7 irq after unmask", {31'b0, irq_o}, 32'h1);
    // R4 write-0 keeps, write-1 clears
    wr(3'd3, ~(32'd1 << 23)); rd(3'd3, d); check("R4 zero write keeps", d, 32'd1 << 23);
    wr(3'd3, 32'd1 << 23);  rd(3'd3, d); check("R4 one write clears", d, 32'h0);

    // R6 priority: n together with every higher source
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
    for (int n = 1; n < 64; n += 5) begin
      @(negedge clk); src_i = ~64'd0 << n;
      @(negedge clk); src_i = '0;
      rd(3'd4, d); check($sformatf("R6 priority low %0d", n), d, {n[5:0], 26'b0});
      if (n < 63) begin
        wr(3'(exp_ofs(n) - 2), ~(32'd1 << exp_pos(n)));
        rd(3'd4, d); check($sformatf("R6 priority masked %0d", n), d, {6'(n + 1), 26'b0});
        wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
      end
      clear_all();
    end

    // R4 set wins over clear in same cycle
    @(negedge clk); src_i = 64'd1 << 20;
    bus_addr = 3'd2; bus_we = 1'b1; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk); bus_we = 1'b0; src_i = '0;
    rd(3'd2, d); check("R4 set beats clear", d, 32'd1 << exp_pos(20));
    clear_all();
    rd(3'd2, d); check("R4 cleared afterwards", d, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule